// File: doc/BRIEF.md
# Interrupt Mask and Enable Controller

This block decides which interrupt a small 8-bit processor core takes, and when. Five request lines come in. The highest is a trap line that cannot be masked. Below it are three vectored restart lines, named by their restart levels 7.5, 6.5 and 5.5, and then a general request line. The core drives three plain strobes:

- An enable strobe sets a global enable flag, one cycle late.
- A disable strobe clears that flag.
- A set-mask strobe carries the low nibble of the accumulator and may load the per-line mask register.

The block samples the request lines and keeps the pending state. It resolves a fixed priority and offers the winning source to the core.

The offer uses a valid/ready handshake. When `irq_valid_o` rises, both it and `irq_vec_o` are registered and stay frozen until the cycle in which `irq_ready_i` is high. That cycle is the acceptance. There is no withdrawal: a disable strobe, a mask write or a line that drops after the offer does not cancel it. The core may hold `irq_ready_i` low for as long as it needs, for example to finish the current instruction.

After acceptance `irq_valid_o` is low for at least one cycle. The controller then arbitrates again from its updated state. A status byte gives the core a read-back of the mask bits, the enable flag and the pending state.

Top module: `int_mask_ctrl`

## Requirements
- R1: The trap line is taken even when the global enable flag is 0 and all mask bits are 1. It is latched on a rising edge and requested only while the line is still high. Acceptance clears the latch, which is visible as status bit 7.
- R2: A set-mask strobe with data bit 3 equal to 0 leaves the mask register unchanged, whatever data bits 2..0 hold.
- R3: A set-mask strobe with data bit 3 equal to 1 loads data bit 0, bit 1 and bit 2 into the masks of restart 5.5, 6.5 and 7.5. A mask bit of 1 blocks the line. Reset leaves all three masks at 1.
- R4: After reset the enable flag is 0. The enable strobe sets the flag at the second rising edge after the strobe cycle. A disable strobe clears the flag at the next edge, and it overrides an enable that is completing in the same cycle.
- R5: Masking a line does not clear its pending state. When a pending restart line is unmasked while the enable flag is 1, an interrupt for that line is offered.
- R6: While the enable flag is 0, no maskable source is offered, whatever the mask bits hold.
- R7: Priority from highest to lowest is trap, restart 7.5, restart 6.5, restart 5.5, general request. The vector codes are 4, 3, 2, 1 and 0. The mask register has no effect on the general request line.
- R8: Restart 7.5 is caught by a rising-edge latch that is held until its acceptance. Restart 6.5, restart 5.5 and the general request line follow their sampled levels.
- R9: Accepting a maskable source (vector 0 to 3) clears the enable flag. Accepting the trap does not change the flag. An enable completing at the acceptance edge leaves the flag at 1.
- R10: Once `irq_valid_o` is high, it and `irq_vec_o` stay unchanged until the handshake. In the cycle after the handshake `irq_valid_o` is 0.
- R11: The status bits are as follows:
  - Bits 2..0 hold the masks of restart 5.5, 6.5 and 7.5.
  - Bit 3 holds the enable flag.
  - Bits 4 and 5 hold the sampled levels of restart 5.5 and 6.5.
  - Bit 6 holds the restart 7.5 latch.
  - Bit 7 holds the trap latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trap_i | input | 1 | Non-maskable trap request |
| rst75_i | input | 1 | Restart 7.5 request (edge) |
| rst65_i | input | 1 | Restart 6.5 request (level) |
| rst55_i | input | 1 | Restart 5.5 request (level) |
| intr_i | input | 1 | General request (level) |
| ei_stb_i | input | 1 | Enable instruction strobe |
| di_stb_i | input | 1 | Disable instruction strobe |
| sim_stb_i | input | 1 | Set-mask instruction strobe |
| sim_data_i | input | 4 | Low accumulator nibble for the set-mask write |
| irq_valid_o | output | 1 | Interrupt offer valid |
| irq_ready_i | input | 1 | Core accepts the offer |
| irq_vec_o | output | 3 | Vector code of the offered source |
| status_o | output | 8 | Read-back of masks, enable flag and pending state |

## Verification
Two operations can land on the same clock edge: the core accepts a maskable source, which clears the enable flag, and a pending enable completes, which sets it. The bench provokes this by issuing the enable strobe exactly one cycle before it raises `irq_ready_i`. It judges the result at the status port, where the flag must read 1, and by watching the same general request be offered again after the one-cycle gap. A second overlap, acceptance of the trap while restart 7.5 is also latched, is judged by the order of the two vectors and by the enable flag surviving the trap.

// File: rtl/imc_pkg.sv
package imc_pkg;
  // request line indices double as vector codes; higher index wins
  localparam int unsigned NUM_LINES = 5;
  localparam int unsigned VEC_W     = $clog2(NUM_LINES);
  localparam int unsigned MASK_W    = 3;   // restart 5.5, 6.5, 7.5
  localparam int unsigned MSE_BIT   = 3;   // mask-set-enable bit of the write
  localparam int unsigned SIM_W     = MSE_BIT + 1;
  localparam int unsigned STAT_W    = MASK_W + 1 + 4;

  typedef enum logic [VEC_W-1:0] {
    SRC_INTR = 3'd0,
    SRC_R55  = 3'd1,
    SRC_R65  = 3'd2,
    SRC_R75  = 3'd3,
    SRC_TRAP = 3'd4
  } src_e;
endpackage

// File: rtl/imc_line_sampler.sv
module imc_line_sampler #(
  parameter int unsigned W = imc_pkg::NUM_LINES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  generate
    for (genvar g = 0; g < W; g++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lvl_o[g]  <= 1'b0;
          prev_q[g] <= 1'b0;
        end else begin
          lvl_o[g]  <= raw_i[g];
          prev_q[g] <= lvl_o[g];
        end
      end

      assign rise_o[g] = lvl_o[g] & ~prev_q[g];

      AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) rise_o[g] |=> !rise_o[g]); // R8
    end
  endgenerate
endmodule

// File: rtl/imc_mask_enable.sv
module imc_mask_enable #(
  parameter int unsigned MASK_W   = imc_pkg::MASK_W,
  parameter int unsigned MSE_BIT  = imc_pkg::MSE_BIT,
  parameter int unsigned SIM_W    = MSE_BIT + 1,
  parameter logic [MASK_W-1:0] MASK_RST = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ei_stb_i,
  input  logic              di_stb_i,
  input  logic              sim_stb_i,
  input  logic [SIM_W-1:0]  sim_data_i,
  input  logic              accept_maskable_i,
  output logic              ie_o,
  output logic [MASK_W-1:0] mask_o
);
  logic arm_q;
  logic ie_q;
  logic [MASK_W-1:0] mask_q;
  logic mask_load;

  // enable takes hold one cycle after its strobe (one instruction later)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_q <= 1'b0;
    else        arm_q <= ei_stb_i & ~di_stb_i;
  end

  // disable beats a completing enable; a completing enable beats acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 ie_q <= 1'b0;
    else if (di_stb_i)          ie_q <= 1'b0;
    else if (arm_q)             ie_q <= 1'b1;
    else if (accept_maskable_i) ie_q <= 1'b0;
  end

  assign mask_load = sim_stb_i & sim_data_i[MSE_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mask_q <= MASK_RST;
    else if (mask_load) mask_q <= sim_data_i[MASK_W-1:0];
  end

  assign ie_o   = ie_q;
  assign mask_o = mask_q;

  AST_SIM_NO_MSE: assert property (@(posedge clk) disable iff (!rst_n) (sim_stb_i && !sim_data_i[MSE_BIT]) |=> $stable(mask_q)); // R2
  AST_SIM_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (sim_stb_i && sim_data_i[MSE_BIT]) |=> (mask_q == $past(sim_data_i[MASK_W-1:0]))); // R3
  AST_EI_DELAY: assert property (@(posedge clk) disable iff (!rst_n) (arm_q && !di_stb_i) |=> ie_q); // R4
  AST_DI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) di_stb_i |=> !ie_q); // R4
  AST_ACCEPT_DROPS_IE: assert property (@(posedge clk) disable iff (!rst_n) (accept_maskable_i && !arm_q) |=> !ie_q); // R9
endmodule

// File: rtl/imc_pending.sv
module imc_pending #(
  parameter int unsigned W = imc_pkg::NUM_LINES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] rise_i,
  input  logic         clr_trap_i,
  input  logic         clr_r75_i,
  output logic [W-1:0] pend_o,
  output logic         lat_trap_o,
  output logic         lat_r75_o
);
  import imc_pkg::*;

  logic lat_trap_q;
  logic lat_r75_q;

  // a fresh edge wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    lat_r75_q <= 1'b0;
    else if (rise_i[SRC_R75])      lat_r75_q <= 1'b1;
    else if (clr_r75_i)            lat_r75_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    lat_trap_q <= 1'b0;
    else if (rise_i[SRC_TRAP])     lat_trap_q <= 1'b1;
    else if (clr_trap_i)           lat_trap_q <= 1'b0;
  end

  always_comb begin
    pend_o           = lvl_i;
    pend_o[SRC_R75]  = lat_r75_q;
    pend_o[SRC_TRAP] = lat_trap_q & lvl_i[SRC_TRAP];
  end

  assign lat_trap_o = lat_trap_q;
  assign lat_r75_o  = lat_r75_q;

  AST_R75_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (lat_r75_q && !clr_r75_i) |=> lat_r75_q); // R8
  AST_TRAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (lat_trap_q && !clr_trap_i) |=> lat_trap_q); // R1
endmodule

// File: rtl/imc_arbiter.sv
module imc_arbiter #(
  parameter int unsigned W      = imc_pkg::NUM_LINES,
  parameter int unsigned MASK_W = imc_pkg::MASK_W,
  parameter int unsigned VEC_W  = imc_pkg::VEC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      pend_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic              ie_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              accept_o,
  output logic              accept_trap_o,
  output logic              accept_r75_o,
  output logic              accept_maskable_o
);
  import imc_pkg::*;

  logic [W-1:0]     elig;
  logic             any_elig;
  logic [VEC_W-1:0] win;
  logic             valid_q;
  logic [VEC_W-1:0] vec_q;

  generate
    for (genvar g = 0; g < W; g++) begin : g_elig
      if (g == int'(SRC_TRAP)) begin : g_nmi
        assign elig[g] = pend_i[g];
      end else if (g == int'(SRC_INTR)) begin : g_gen
        assign elig[g] = pend_i[g] & ie_i;
      end else begin : g_rst
        assign elig[g] = pend_i[g] & ie_i & ~mask_i[g-1];
      end
    end
  endgenerate

  // fixed priority: the highest index present wins
  always_comb begin
    win = '0;
    for (int i = 0; i < W; i++) begin
      if (elig[i]) win = VEC_W'(i);
    end
  end

  assign any_elig = |elig;
  assign accept_o = valid_q & ready_i;

  // the offer is committed: held until taken, then one idle cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      vec_q   <= '0;
    end else if (accept_o) begin
      valid_q <= 1'b0;
    end else if (!valid_q && any_elig) begin
      valid_q <= 1'b1;
      vec_q   <= win;
    end
  end

  assign valid_o           = valid_q;
  assign vec_o             = vec_q;
  assign accept_trap_o     = accept_o & (vec_q == SRC_TRAP);
  assign accept_r75_o      = accept_o & (vec_q == SRC_R75);
  assign accept_maskable_o = accept_o & (vec_q != SRC_TRAP);

  AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n) (valid_q && !ready_i) |=> (valid_q && $stable(vec_q))); // R10
  AST_GAP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) accept_o |=> !valid_q); // R10
  AST_TRAP_UNBLOCKED: assert property (@(posedge clk) disable iff (!rst_n) (!valid_q && pend_i[SRC_TRAP]) |=> (valid_q && vec_q == SRC_TRAP)); // R1
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (!valid_q && !ie_i && !pend_i[SRC_TRAP]) |=> !valid_q); // R6
endmodule

// File: rtl/int_mask_ctrl.sv
module int_mask_ctrl #(
  parameter int unsigned NUM_LINES = imc_pkg::NUM_LINES,
  parameter int unsigned MASK_W    = imc_pkg::MASK_W,
  parameter int unsigned MSE_BIT   = imc_pkg::MSE_BIT,
  parameter int unsigned SIM_W     = MSE_BIT + 1,
  parameter int unsigned VEC_W     = $clog2(NUM_LINES),
  parameter int unsigned STAT_W    = MASK_W + 1 + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_i,
  input  logic              rst75_i,
  input  logic              rst65_i,
  input  logic              rst55_i,
  input  logic              intr_i,
  input  logic              ei_stb_i,
  input  logic              di_stb_i,
  input  logic              sim_stb_i,
  input  logic [SIM_W-1:0]  sim_data_i,
  output logic              irq_valid_o,
  input  logic              irq_ready_i,
  output logic [VEC_W-1:0]  irq_vec_o,
  output logic [STAT_W-1:0] status_o
);
  import imc_pkg::*;

  logic [NUM_LINES-1:0] raw;
  logic [NUM_LINES-1:0] lvl;
  logic [NUM_LINES-1:0] rise;
  logic [NUM_LINES-1:0] pend;
  logic [MASK_W-1:0]    mask;
  logic                 ie;
  logic                 lat_trap;
  logic                 lat_r75;
  logic                 acc_any;
  logic                 acc_trap;
  logic                 acc_r75;
  logic                 acc_mask;

  always_comb begin
    raw           = '0;
    raw[SRC_INTR] = intr_i;
    raw[SRC_R55]  = rst55_i;
    raw[SRC_R65]  = rst65_i;
    raw[SRC_R75]  = rst75_i;
    raw[SRC_TRAP] = trap_i;
  end

  imc_line_sampler #(.W(NUM_LINES)) u_sample (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  (raw),
    .lvl_o  (lvl),
    .rise_o (rise)
  );

  imc_mask_enable #(.MASK_W(MASK_W), .MSE_BIT(MSE_BIT), .SIM_W(SIM_W)) u_mask (
    .clk               (clk),
    .rst_n             (rst_n),
    .ei_stb_i          (ei_stb_i),
    .di_stb_i          (di_stb_i),
    .sim_stb_i         (sim_stb_i),
    .sim_data_i        (sim_data_i),
    .accept_maskable_i (acc_mask),
    .ie_o              (ie),
    .mask_o            (mask)
  );

  imc_pending #(.W(NUM_LINES)) u_pend (
    .clk        (clk),
    .rst_n      (rst_n),
    .lvl_i      (lvl),
    .rise_i     (rise),
    .clr_trap_i (acc_trap),
    .clr_r75_i  (acc_r75),
    .pend_o     (pend),
    .lat_trap_o (lat_trap),
    .lat_r75_o  (lat_r75)
  );

  imc_arbiter #(.W(NUM_LINES), .MASK_W(MASK_W), .VEC_W(VEC_W)) u_arb (
    .clk               (clk),
    .rst_n             (rst_n),
    .pend_i            (pend),
    .mask_i            (mask),
    .ie_i              (ie),
    .ready_i           (irq_ready_i),
    .valid_o           (irq_valid_o),
    .vec_o             (irq_vec_o),
    .accept_o          (acc_any),
    .accept_trap_o     (acc_trap),
    .accept_r75_o      (acc_r75),
    .accept_maskable_o (acc_mask)
  );

  assign status_o = {lat_trap, lat_r75, lvl[SRC_R65], lvl[SRC_R55], ie, mask};

  AST_TRAP_KEEPS_IE: assert property (@(posedge clk) disable iff (!rst_n) (acc_any && acc_trap && !di_stb_i) |=> (ie == $past(ie) || $past(u_mask.arm_q))); // R9
  AST_MASK_KEEPS_PENDING: assert property (@(posedge clk) disable iff (!rst_n) (lat_r75 && mask[2] && !acc_r75) |=> lat_r75); // R5
endmodule

// File: tb/tb_int_mask_ctrl.sv
module tb_int_mask_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] lines = '0;   // {trap, r75, r65, r55, intr}
  logic       ei = 1'b0, di = 1'b0, simw = 1'b0, ready = 1'b0;
  logic [3:0] simd = '0;
  logic       valid;
  logic [2:0] vec;
  logic [7:0] status;

  int nvec  = 0;
  int nfail = 0;

  always #4 clk = ~clk;   // 125 MHz

  int_mask_ctrl dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .trap_i      (lines[4]),
    .rst75_i     (lines[3]),
    .rst65_i     (lines[2]),
    .rst55_i     (lines[1]),
    .intr_i      (lines[0]),
    .ei_stb_i    (ei),
    .di_stb_i    (di),
    .sim_stb_i   (simw),
    .sim_data_i  (simd),
    .irq_valid_o (valid),
    .irq_ready_i (ready),
    .irq_vec_o   (vec),
    .status_o    (status)
  );

  typedef struct packed {
    logic       ei;
    logic       di;
    logic       simw;
    logic [3:0] simd;
    logic [4:0] lines;
    logic       acc;
    logic       ev;
    logic [2:0] evec;
    logic [7:0] est;
  } vrow_t;

  localparam int NV = 12;
  localparam vrow_t TBL [NV] = '{
    '{1'b0, 1'b0, 1'b0, 4'h0, 5'b00000, 1'b0, 1'b0, 3'd0, 8'h07},
    '{1'b0, 1'b0, 1'b0, 4'h0, 5'b00010, 1'b0, 1'b0, 3'd0, 8'h17},
    '{1'b0, 1'b0, 1'b1, 4'h8, 5'b00010, 1'b0, 1'b0, 3'd0, 8'h10},
    '{1'b1, 1'b0, 1'b0, 4'h0, 5'b00010, 1'b1, 1'b1, 3'd1, 8'h18},
    '{1'b0, 1'b0, 1'b0, 4'h0, 5'b00000, 1'b0, 1'b0, 3'd0, 8'h00},
    '{1'b0, 1'b0, 1'b1, 4'hC, 5'b01000, 1'b0, 1'b0, 3'd0, 8'h44},
    '{1'b1, 1'b0, 1'b0, 4'h0, 5'b00000, 1'b0, 1'b0, 3'd0, 8'h4C},
    '{1'b0, 1'b0, 1'b1, 4'h8, 5'b00000, 1'b1, 1'b1, 3'd3, 8'h48},
    '{1'b0, 1'b0, 1'b1, 4'h7, 5'b00000, 1'b0, 1'b0, 3'd0, 8'h00},
    '{1'b0, 1'b0, 1'b1, 4'hF, 5'b10000, 1'b1, 1'b1, 3'd4, 8'h87},
    '{1'b1, 1'b0, 1'b0, 4'h0, 5'b00111, 1'b1, 1'b1, 3'd0, 8'h3F},
    '{1'b1, 1'b0, 1'b1, 4'h8, 5'b00111, 1'b1, 1'b1, 3'd2, 8'h38}
  };

  function automatic string tag_of(int i);
    case (i)
      0, 4:  return "R11";
      1:     return "R6";
      2, 11: return "R3";
      3:     return "R4";
      5:     return "R8";
      6, 7:  return "R5";
      8:     return "R2";
      9:     return "R1";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ei();
    ei = 1'b1; step(1); ei = 1'b0;
  endtask

  task automatic take();
    ready = 1'b1; step(1); ready = 1'b0;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    step(2);
    rst_n = 1'b1;
    step(1);
    // reset state: masks all set, enable clear, nothing offered
    chk("R3", "reset status", status, 8'h07);
    chk("R4", "reset valid", {7'd0, valid}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      ei = TBL[i].ei; di = TBL[i].di; simw = TBL[i].simw; simd = TBL[i].simd;
      lines = TBL[i].lines;
      step(1);
      ei = 1'b0; di = 1'b0; simw = 1'b0;
      step(4);
      chk(tag_of(i), "table valid", {7'd0, valid}, {7'd0, TBL[i].ev});
      if (TBL[i].ev) chk(tag_of(i), "table vector", {5'd0, vec}, {5'd0, TBL[i].evec});
      chk(tag_of(i), "table status", status, TBL[i].est);
      if (TBL[i].acc) begin
        take();
        step(2);
      end
    end

    // R7 / R9: trap and 7.5 together; trap first, enable survives it
    lines = '0; step(3);
    pulse_ei(); step(3);
    lines = 5'b11000; step(5);
    chk("R7", "trap over r75 valid", {7'd0, valid}, 8'h01);
    chk("R7", "trap over r75 vector", {5'd0, vec}, 8'h04);
    take();
    chk("R10", "gap after accept", {7'd0, valid}, 8'h00);
    chk("R9", "ie kept after trap", {7'd0, status[3]}, 8'h01);
    step(2);
    chk("R8", "r75 latched offered", {4'd0, valid, vec}, {4'd0, 1'b1, 3'd3});
    take();
    chk("R9", "ie cleared by r75 accept", {7'd0, status[3]}, 8'h00);
    lines = '0; step(3);

    // R10: offer stays through disable, mask write and line drop
    pulse_ei(); step(1);
    lines = 5'b00010; step(5);
    chk("R10", "offer r55", {4'd0, valid, vec}, {4'd0, 1'b1, 3'd1});
    di = 1'b1; simw = 1'b1; simd = 4'hF; lines = '0;
    step(1);
    di = 1'b0; simw = 1'b0;
    step(3);
    chk("R10", "offer held", {4'd0, valid, vec}, {4'd0, 1'b1, 3'd1});
    chk("R4", "di cleared ie", status, 8'h07);
    take();
    chk("R10", "gap after held offer", {7'd0, valid}, 8'h00);

    // R4: enable timing and disable override
    pulse_ei();
    chk("R4", "ie one edge after strobe", {7'd0, status[3]}, 8'h00);
    step(1);
    chk("R4", "ie two edges after strobe", {7'd0, status[3]}, 8'h01);
    ei = 1'b1; step(1); ei = 1'b0; di = 1'b1; step(1); di = 1'b0;
    chk("R4", "di beats completing ei", {7'd0, status[3]}, 8'h00);

    // R9: acceptance coinciding with a completing enable
    simw = 1'b1; simd = 4'h8; ei = 1'b1; step(1);
    simw = 1'b0; ei = 1'b0;
    lines = 5'b00001; step(5);
    chk("R7", "intr offered", {4'd0, valid, vec}, {4'd0, 1'b1, 3'd0});
    ei = 1'b1; step(1); ei = 1'b0;
    take();
    chk("R9", "ie survives same-cycle accept", {7'd0, status[3]}, 8'h01);
    chk("R10", "gap same-cycle", {7'd0, valid}, 8'h00);
    step(2);
    chk("R8", "intr level re-offered", {4'd0, valid, vec}, {4'd0, 1'b1, 3'd0});
    lines = '0;
    take();
    step(2);

    // R1: trap must be high at request time; latch persists
    lines = 5'b10000; step(1); lines = '0; step(4);
    chk("R1", "trap pulse not offered", {7'd0, valid}, 8'h00);
    chk("R1", "trap latch kept", {7'd0, status[7]}, 8'h01);
    lines = 5'b10000; step(4);
    chk("R1", "trap offered with ie 0", {4'd0, valid, vec}, {4'd0, 1'b1, 3'd4});
    take();
    lines = '0; step(2);
    chk("R1", "trap latch cleared", {7'd0, status[7]}, 8'h00);

    summary();
    $finish;
  end
endmodule